// File: doc/BRIEF.md
# Multiprocessor Receiver Wake-Up Controller

This block decides when a serial receiver that has been put to sleep is allowed to report characters again. Software, or a higher-level protocol engine, raises a one-cycle sleep request when the traffic on a shared multidrop line is not meant for this node. From then on the receiver keeps shifting characters in, but this block stops their completion strobes from being reported as valid data. It releases the receiver when the wake condition for the selected method is met.

Two wake methods are available and are chosen by a mode input. In idle-line mode the block counts bit-rate ticks while the line stays high and wakes once a whole character time of idle has gone by. That is 10 ticks for 8-bit characters and 11 ticks for 9-bit characters. Any low level restarts the count, so short gaps inside a message do not wake the node. In address-mark mode the most significant bit of each completed character tells address characters (1) from data characters (0). An address character wakes the node and is reported itself. Idle time has no effect in this mode.

The line input is assumed to be already synchronised to `clk`. Character completion comes from the receiver's own shifter, which lies outside this block.

Top module: `rx_wake_ctrl`

## Requirements
- R1: After reset `asleep` is 0, and `rx_report` is 0 whenever `char_done` is 0.
- R2: A cycle with `sleep_req`=1 makes `asleep` 1 in the next cycle. This holds whether the node was awake or already asleep, and a request while asleep throws away any idle time counted so far.
- R3: With `wake_sel`=0 (idle-line) and `char9`=0, `asleep` goes to 0 in the cycle after the 10th consecutive `bit_tick` seen with `line_in`=1. After only 9 such ticks it stays 1.
- R4: With `wake_sel`=0 and `char9`=1, 11 consecutive high ticks are needed. After 10 the node stays asleep.
- R5: In idle-line mode, any cycle with `line_in`=0 restarts the idle count from zero.
- R6: Idle ticks that occur before or in the same cycle as a sleep request do not count. A full idle period must follow the request.
- R7: With `wake_sel`=1 (address-mark), a `char_done` with `char_msb`=1 while asleep is reported on `rx_report` in that cycle, and `asleep` is 0 in the next cycle.
- R8: With `wake_sel`=1, a `char_done` with `char_msb`=0 while asleep is not reported and leaves `asleep` at 1.
- R9: With `wake_sel`=1, idle time on the line, however long, never wakes the node.
- R10: While `asleep` is 0, every `char_done` is reported on `rx_report` in the same cycle, in either mode.
- R11: In idle-line mode, characters completed while asleep are not reported, whatever their MSB, and they do not wake the node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle request to enter the dormant state |
| wake_sel | input | 1 | Wake method: 0 idle-line, 1 address-mark |
| char9 | input | 1 | Character format: 0 8-bit (10-bit idle), 1 9-bit (11-bit idle) |
| line_in | input | 1 | Synchronised receive line level |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| char_done | input | 1 | Receiver has completed a character |
| char_msb | input | 1 | MSB of the completed character (1 marks an address) |
| asleep | output | 1 | Dormant status |
| rx_report | output | 1 | Gated character-valid strobe |

## Verification
The bench probes the exact edge of the idle count: 9 versus 10 ticks in 8-bit format and 10 versus 11 in 9-bit format. An off-by-one counter would wake one tick early or late. It breaks an idle stretch with a single low cycle, and a counter that only paused on a low level would then wake too soon. It also makes the sleep request while the line has already been idle. A design that kept the count from before the request would wake right away. In address-mark mode it checks that long idle periods and data characters leave the node asleep, and that the waking address character is itself reported. Dropping that character, or waking on idle, would show up as a scoreboard mismatch.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

   typedef enum logic {
      WAKE_ON_IDLE = 1'b0,
      WAKE_ON_ADDR = 1'b1
   } wake_mode_e;

   // number of idle bit times that make up one full character frame
   function automatic int unsigned frame_bits(input int unsigned data_bits);
      return data_bits + 2;
   endfunction

endpackage

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
   parameter int unsigned SHORT_DATA = 8,
   parameter bit          HAS_LONG   = 1'b1,
   localparam int unsigned SHORT_IDLE = rxw_pkg::frame_bits(SHORT_DATA),
   localparam int unsigned LONG_IDLE  = rxw_pkg::frame_bits(SHORT_DATA + 1),
   localparam int unsigned CNT_W      = $clog2(LONG_IDLE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic line_in,
   input  logic bit_tick,
   input  logic char9,
   output logic hit
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;

   generate
      if (HAS_LONG) begin : g_two_fmt
         assign target = char9 ? CNT_W'(LONG_IDLE) : CNT_W'(SHORT_IDLE);
      end else begin : g_one_fmt
         logic unused_fmt;
         assign unused_fmt = char9;
         assign target     = CNT_W'(SHORT_IDLE);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!arm || !line_in) begin
         cnt_q <= '0;
      end else if (bit_tick && (cnt_q < target)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit = arm && line_in && bit_tick && (cnt_q == target - 1'b1);

   // R5: a low line leaves the count at zero
   a_r5_low_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !line_in) |=> (cnt_q == '0));

   // R6: a disarmed timer holds nothing over
   a_r6_disarm_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> (cnt_q == '0));

   a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(LONG_IDLE));

endmodule

// File: rtl/rxw_sleep_state.sv
module rxw_sleep_state (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake,
   output logic asleep
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         asleep <= 1'b0;
      else if (sleep_req) asleep <= 1'b1;
      else if (wake)      asleep <= 1'b0;
   end

   // R2: request always lands in the dormant state
   a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_req |=> asleep);

   a_r2_stay_without_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !wake) |=> asleep);

endmodule

// File: rtl/rx_wake_ctrl.sv
module rx_wake_ctrl #(
   parameter int unsigned DATA_BITS = 8,
   parameter bit          NINE_BIT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic wake_sel,
   input  logic char9,
   input  logic line_in,
   input  logic bit_tick,
   input  logic char_done,
   input  logic char_msb,
   output logic asleep,
   output logic rx_report
);
   import rxw_pkg::*;

   generate
      if (DATA_BITS < 5 || DATA_BITS > 16) begin : g_bad_bits
         $error("rx_wake_ctrl: DATA_BITS out of range");
      end
   endgenerate

   wake_mode_e mode;
   logic       idle_arm;
   logic       idle_hit;
   logic       addr_hit;
   logic       wake;

   assign mode     = wake_mode_e'(wake_sel);
   assign idle_arm = asleep && (mode == WAKE_ON_IDLE) && !sleep_req;
   assign addr_hit = asleep && (mode == WAKE_ON_ADDR) && char_done && char_msb;
   assign wake     = idle_hit || addr_hit;

   rxw_idle_timer #(
      .SHORT_DATA (DATA_BITS),
      .HAS_LONG   (NINE_BIT)
   ) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (idle_arm),
      .line_in  (line_in),
      .bit_tick (bit_tick),
      .char9    (char9),
      .hit      (idle_hit)
   );

   rxw_sleep_state u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep_req (sleep_req),
      .wake      (wake),
      .asleep    (asleep)
   );

   assign rx_report = char_done && (!asleep || addr_hit);

   // R10: awake characters always pass
   a_r10_awake_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && char_done) |-> rx_report);

   // R8 / R11: dormant non-address characters are blocked
   a_r8_dormant_block: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && char_done && !(wake_sel && char_msb)) |-> !rx_report);

   // R9: address-mark mode never wakes without a character
   a_r9_no_idle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && wake_sel && !char_done) |=> asleep);

   // R7: address character wakes the node
   a_r7_addr_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && wake_sel && char_done && char_msb && !sleep_req) |=> !asleep);

   // R1: nothing reported without a completed character
   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !char_done |-> !rx_report);

endmodule

// File: tb/tb_rx_wake_ctrl.sv
module tb_rx_wake_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 0, wake_sel = 0, char9 = 0, line_in = 1;
   logic bit_tick = 0, char_done = 0, char_msb = 0;
   logic asleep, rx_report;

   int n_cmp = 0;
   int n_bad = 0;
   bit exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   rx_wake_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_sel(wake_sel),
      .char9(char9), .line_in(line_in), .bit_tick(bit_tick),
      .char_done(char_done), .char_msb(char_msb),
      .asleep(asleep), .rx_report(rx_report)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   // one clock with the given strobes; returns at posedge+1
   task automatic cyc(input logic sr, input logic tk, input logic ln,
                      input logic cd, input logic msb);
      sleep_req = sr; bit_tick = tk; line_in = ln; char_done = cd; char_msb = msb;
      @(posedge clk); #1;
      sleep_req = 0; bit_tick = 0; char_done = 0; char_msb = 0;
   endtask

   task automatic ticks(input int n, input logic ln);
      for (int i = 0; i < n; i++) cyc(0, 1, ln, 0, 0);
   endtask

   task automatic send_char(input logic msb, input bit exp, input string tag);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      cyc(0, 0, 1, 1, msb);
   endtask

   task automatic go_sleep(input string tag);
      cyc(1, 0, 1, 0, 0);
      check(tag, asleep, 1'b1);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && char_done) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R10: unexpected character, got %b expected none", rx_report);
         end else begin
            check(tag_q.pop_front(), rx_report, exp_q.pop_front());
         end
      end
   end

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset asleep", asleep, 1'b0);
      check("R1 reset report", rx_report, 1'b0);
      rst_n = 1'b1;
      cyc(0, 0, 1, 0, 0);

      // idle-line mode, 8-bit
      send_char(0, 1, "R10 awake idle-mode char");
      go_sleep("R2 enter sleep");
      send_char(0, 0, "R11 dormant data char blocked");
      send_char(1, 0, "R11 dormant msb char blocked");
      check("R11 still asleep", asleep, 1'b1);
      ticks(9, 1);
      check("R3 nine ticks not enough", asleep, 1'b1);
      ticks(1, 1);
      check("R3 wake after ten", asleep, 1'b0);

      go_sleep("R2 enter sleep again");
      ticks(6, 1);
      cyc(0, 1, 0, 0, 0);
      ticks(9, 1);
      check("R5 low restarts count", asleep, 1'b1);
      ticks(1, 1);
      check("R5 wake after full run", asleep, 1'b0);

      // 9-bit format
      char9 = 1;
      go_sleep("R2 sleep 9-bit");
      ticks(10, 1);
      check("R4 ten ticks not enough", asleep, 1'b1);
      ticks(1, 1);
      check("R4 wake after eleven", asleep, 1'b0);
      char9 = 0;

      // request while line already idle
      ticks(8, 1);
      cyc(1, 1, 1, 0, 0);
      check("R6 request with idle line", asleep, 1'b1);
      ticks(9, 1);
      check("R6 earlier idle not counted", asleep, 1'b1);
      ticks(1, 1);
      check("R6 wake after fresh period", asleep, 1'b0);

      // re-request while asleep restarts
      go_sleep("R2 sleep before restart");
      ticks(8, 1);
      go_sleep("R2 re-request while asleep");
      ticks(9, 1);
      check("R2 restart discards count", asleep, 1'b1);
      ticks(1, 1);
      check("R2 wake after restart", asleep, 1'b0);

      // address-mark mode
      wake_sel = 1;
      send_char(1, 1, "R10 awake addr-mode char");
      go_sleep("R2 sleep addr mode");
      ticks(40, 1);
      check("R9 idle does not wake", asleep, 1'b1);
      send_char(0, 0, "R8 data char blocked");
      check("R8 still asleep", asleep, 1'b1);
      send_char(1, 1, "R7 address char reported");
      check("R7 wake on address", asleep, 1'b0);
      send_char(0, 1, "R10 data after wake");

      repeat (3) cyc(0, 0, 1, 0, 0);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R10: got %0d pending expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule